// File: doc/BRIEF.md
# Opcode Escape-Prefix Sequencer

This block sits between the opcode fetch path of an 8-bit processor and its instruction decoder. Fetched bytes arrive one per cycle while `byteValid` is high. Four escape byte values (0xED, 0xCB, 0xDD, 0xFD) are not opcodes in their own right. Each one adds a bit to a 4-bit table-select class. The first byte that is not taken as a prefix ends the sequence. In that same cycle the block presents the byte as the opcode, along with the accumulated class that tells the decoder which table to use.

Chaining is restricted. A prefix byte counts as a further prefix only when the prefix just before it was one of the two index escapes (0xDD or 0xFD). In every other case the byte is handed to the decoder as the opcode. Only a few of the possible classes name a real table. Every other class is flagged invalid, and the opcode is replaced by 0x00 so that the instruction executes as a no-operation.

Top module: `pfx_sequencer`

## Requirements
- R1: After a synchronous reset, `prefixClass` is 0000 and `opDone` and `comboInvalid` are low until a non-prefix byte is accepted.
- R2: With the class empty, an accepted byte 0xED sets class bit 0, 0xCB sets bit 1, 0xDD sets bit 2 and 0xFD sets bit 3. No done strobe is produced for that byte.
- R3: When the class is not empty, a prefix byte is accumulated only if the previously accepted prefix was 0xDD or 0xFD. Otherwise it completes the sequence as the opcode.
- R4: `opDone` is high in exactly the cycle in which a non-prefix byte is accepted, combinationally with that byte. `prefixClass` then shows the class accumulated before that byte.
- R5: On the clock edge that ends a done cycle, the class returns to 0000 and the previous-prefix history is cleared.
- R6: `comboInvalid` is high only together with `opDone`, and exactly when the class is not one of 0000, 0001, 0010, 0100, 0110, 1000 or 1010.
- R7: In a done cycle with an invalid class, `opByte` is 0x00 (no-operation). Otherwise `opByte` equals `byteIn`.
- R8: While `byteValid` is low, `opDone` stays low and the class and history do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | A fetched byte is present on byteIn |
| byteIn | input | 8 | Fetched opcode stream byte |
| opDone | output | 1 | Sequence completes with this byte |
| opByte | output | 8 | Opcode for the decoder (0x00 when invalid) |
| prefixClass | output | 4 | Decode table select, one bit per escape kind |
| comboInvalid | output | 1 | Class names no decode table |

## Verification
Directed sequences cover each single escape, the two legal index-then-bit-table chains, and repeated index escapes (DD DD, DD FD). They also cover a non-index escape followed by another escape byte (ED CB, DD CB CB), which must be emitted as an opcode, and DD ED, which must produce an invalid class. Together these separate the chaining rule from plain accumulation and exercise the invalid path. Random streams biased toward escape bytes, with idle cycles mixed in, show that idle cycles leave the state untouched and that every reachable class gets the right valid/invalid verdict and opcode substitution.

// File: rtl/pfx_seq_pkg.sv
package pfx_seq_pkg;

  typedef struct packed {
    logic accumulate;  // fold current byte into the class
    logic clear;       // sequence ends, empty the class
  } seqStrobe_t;

  // Classes that name a real decode table.
  function automatic logic classIsValid(input logic [3:0] cls);
    case (cls)
      4'b0000, 4'b0001, 4'b0010, 4'b0100,
      4'b0110, 4'b1000, 4'b1010: classIsValid = 1'b1;
      default:                   classIsValid = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pfx_seq_ctrl.sv
module pfx_seq_ctrl
  import pfx_seq_pkg::*;
#(
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byteValid,
  input  logic [CLASS_W-1:0] hitVec,
  input  logic [CLASS_W-1:0] prefixReg,
  input  logic               lastWasIndex,
  output seqStrobe_t         strobes,
  output logic               opDone
);

  logic isPrefixByte;
  logic mayChain;
  logic takePrefix;

  always_comb begin
    isPrefixByte = |hitVec;
    mayChain     = (prefixReg == '0) || lastWasIndex;
    takePrefix   = byteValid && isPrefixByte && mayChain;
    opDone       = byteValid && !takePrefix;
    strobes.accumulate = takePrefix;
    strobes.clear      = opDone;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.accumulate && strobes.clear));

  // R8
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> !opDone && !strobes.accumulate);

endmodule

// File: rtl/pfx_seq_dp.sv
module pfx_seq_dp
  import pfx_seq_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               CLASS_W    = 4,
  parameter logic [CLASS_W-1:0][DATA_W-1:0] PFX_CODES = '0,
  parameter logic [CLASS_W-1:0] INDEX_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  byteIn,
  input  seqStrobe_t         strobes,
  output logic [CLASS_W-1:0] hitVec,
  output logic [CLASS_W-1:0] prefixReg,
  output logic               lastWasIndex,
  output logic [DATA_W-1:0]  opByte,
  output logic               comboInvalid
);

  genvar g;
  generate
    for (g = 0; g < CLASS_W; g++) begin : g_match
      assign hitVec[g] = (byteIn == PFX_CODES[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobes.clear) begin
      prefixReg    <= '0;
      lastWasIndex <= 1'b0;
    end else if (strobes.accumulate) begin
      prefixReg    <= prefixReg | hitVec;
      lastWasIndex <= |(hitVec & INDEX_MASK);
    end
  end

  always_comb begin
    comboInvalid = strobes.clear && !classIsValid(prefixReg);
    opByte       = comboInvalid ? '0 : byteIn;
  end

  // R5
  clear_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clear |=> (prefixReg == '0) && !lastWasIndex);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.accumulate && !strobes.clear |=> $stable(prefixReg) && $stable(lastWasIndex));

  // R2
  accum_grows_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.accumulate |=> (prefixReg & $past(prefixReg)) == $past(prefixReg));

endmodule

// File: rtl/pfx_sequencer.sv
module pfx_sequencer
  import pfx_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byteValid,
  input  logic [DATA_W-1:0]  byteIn,
  output logic               opDone,
  output logic [DATA_W-1:0]  opByte,
  output logic [CLASS_W-1:0] prefixClass,
  output logic               comboInvalid
);

  // bit order: 0=ED, 1=CB, 2=DD, 3=FD
  localparam logic [CLASS_W-1:0][DATA_W-1:0] PFX_CODES =
    {8'hFD, 8'hDD, 8'hCB, 8'hED};
  localparam logic [CLASS_W-1:0] INDEX_MASK = 4'b1100;

  seqStrobe_t         strobes;
  logic [CLASS_W-1:0] hitVec;
  logic [CLASS_W-1:0] prefixReg;
  logic               lastWasIndex;

  pfx_seq_ctrl #(.CLASS_W(CLASS_W)) ctrl_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .hitVec(hitVec),
    .prefixReg(prefixReg), .lastWasIndex(lastWasIndex),
    .strobes(strobes), .opDone(opDone)
  );

  pfx_seq_dp #(
    .DATA_W(DATA_W), .CLASS_W(CLASS_W),
    .PFX_CODES(PFX_CODES), .INDEX_MASK(INDEX_MASK)
  ) dp_i (
    .clk(clk), .rst(rst), .byteIn(byteIn), .strobes(strobes),
    .hitVec(hitVec), .prefixReg(prefixReg), .lastWasIndex(lastWasIndex),
    .opByte(opByte), .comboInvalid(comboInvalid)
  );

  assign prefixClass = prefixReg;

  // R6
  invalid_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    comboInvalid |-> opDone);

  // R7
  nop_on_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    comboInvalid |-> opByte == '0);

  // R7
  pass_when_valid_chk: assert property (@(posedge clk) disable iff (rst)
    opDone && !comboInvalid |-> opByte == byteIn);

endmodule

// File: tb/pfx_sequencer_tb.sv
module pfx_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       byteValid;
  logic [7:0] byteIn;
  logic       opDone;
  logic [7:0] opByte;
  logic [3:0] prefixClass;
  logic       comboInvalid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [3:0] mCls;
  bit         mIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_sequencer dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn),
    .opDone(opDone), .opByte(opByte), .prefixClass(prefixClass),
    .comboInvalid(comboInvalid)
  );

  function automatic logic [3:0] bitOf(input logic [7:0] b);
    case (b)
      8'hED: return 4'b0001;
      8'hCB: return 4'b0010;
      8'hDD: return 4'b0100;
      8'hFD: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic bit okClass(input logic [3:0] c);
    return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd6, 4'd8, 4'd10};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle, check outputs before the edge, then advance the model
  task automatic step(input bit v, input logic [7:0] b);
    bit takes, eDone, eInv;
    logic [7:0] eOp;
    @(negedge clk);
    byteValid = v;
    byteIn    = b;
    #1;
    takes = v && (bitOf(b) != 0) && (mCls == 0 || mIdx);
    eDone = v && !takes;
    eInv  = eDone && !okClass(mCls);
    eOp   = eInv ? 8'h00 : b;
    check(opDone == eDone, v ? "R4 done" : "R8 idle done", opDone, eDone);
    check(prefixClass == mCls, takes ? "R2/R3 class" : "R4 class", prefixClass, mCls);
    check(comboInvalid == eInv, "R6 invalid", comboInvalid, eInv);
    if (eDone) check(opByte == eOp, "R7 opByte", opByte, eOp);
    @(posedge clk);
    if (eDone) begin
      mCls = 0; mIdx = 0;
    end else if (takes) begin
      mCls = mCls | bitOf(b);
      mIdx = (b == 8'hDD) || (b == 8'hFD);
    end
  endtask

  task automatic sendSeq(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input int n);
    step(1, a);
    if (n > 1) step(1, b);
    if (n > 2) step(1, c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [8];
    void'($urandom(32'h5eed_1234));
    pool = '{8'hED, 8'hCB, 8'hDD, 8'hFD, 8'h00, 8'h3E, 8'hC3, 8'h76};
    mCls = 0; mIdx = 0;
    rst = 1'b1; byteValid = 1'b0; byteIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(prefixClass == 4'd0, "R1 class", prefixClass, 0);
    check(opDone == 1'b0, "R1 done", opDone, 0);
    check(comboInvalid == 1'b0, "R1 invalid", comboInvalid, 0);

    sendSeq(8'h3E, 0, 0, 1);          // plain opcode, class 0000
    sendSeq(8'hED, 8'h47, 0, 2);      // R2 ED
    sendSeq(8'hCB, 8'hED, 0, 2);      // R3 CB then ED -> ED is opcode
    sendSeq(8'hDD, 8'hCB, 8'h06, 3);  // 0110, then 06 opcode
    sendSeq(8'hDD, 8'hCB, 8'hCB, 3);  // R3 second CB is opcode
    sendSeq(8'hFD, 8'hCB, 8'h46, 3);  // 1010
    sendSeq(8'hDD, 8'hED, 8'h55, 3);  // R6 0101 invalid, R7 nop
    sendSeq(8'hDD, 8'hFD, 8'h21, 3);  // R6 1100 invalid
    sendSeq(8'hDD, 8'hDD, 8'h21, 3);  // index repeat stays 0100
    sendSeq(8'hED, 8'hCB, 0, 2);      // R3 non-index then prefix
    step(1, 8'hFD);
    step(0, 8'hED);                   // R8 idle ignored
    step(0, 8'h00);
    step(1, 8'h09);                   // R5 then clears

    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 5) != 0;
      logic [7:0] b = ($urandom % 3 != 0) ? pool[$urandom % 8] : 8'($urandom);
      step(v, b);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule